// File: doc/BRIEF.md
# Millisecond Power-of-Two Input Debouncer

This block cleans up one already-synchronised input pin before it reaches edge detection. While filtering is on, a new level on the raw input reaches the filtered output only after it has held without a break for a whole window. The window is 2^code milliseconds, so it runs from 1 ms up to 128 ms. A free-running prescaler counts system clocks into milliseconds, and a second counter counts the elapsed milliseconds. The cycles in one millisecond are set by a parameter.

The pin's control word is given to the block unchanged. It reads two fields: an enable bit and a 3-bit exponent. Every other bit of the word is ignored. While the enable is clear the raw level goes straight to the output and the internal level follows it. Any change to either field restarts the window, and the output keeps its present value during the restart.

Top module: `ms_debounce_filter`

## Requirements
- R1: With the enable set and the configuration steady, the filtered output keeps its value while the raw input has differed from it for fewer than CYCLES_PER_MS * 2^code consecutive clock edges.
- R2: On the CYCLES_PER_MS * 2^code-th consecutive clock edge at which the raw input differs, the filtered output takes the raw value.
- R3: The enable is bit 8 of the control word. When it is 0, the filtered output equals the raw input combinationally. When the enable is next set, the output starts from the last raw level.
- R4: The code is bits [7:5] of the control word and selects a window of 2^code ms. Codes 0 to 7 give 1 to 128 ms.
- R5: A clock edge at which the raw input equals the filtered output restarts the count. A glitch shorter than the window never reaches the output.
- R6: A change of the code or the enable restarts the count at that edge, and the filtered output holds its value.
- R7: While reset is asserted, the filtered output loads the raw level at every clock edge, with no filtering. After reset is released, the output starts from that level.
- R8: Control-word bits [4:0] have no effect on the output and do not restart the count.
- R9: One millisecond is CYCLES_PER_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| rawIn | input | 1 | Synchronised raw pin level |
| ctrlWord | input | 9 | Pin control word: bit 8 enable, bits [7:5] window code |
| filtOut | output | 1 | Filtered level |

## Verification
The checker assumes that rawIn and ctrlWord change only between clock edges, so each edge sees one steady value. It also assumes that the window is at least one cycle long. The bench drives every input on the falling edge and samples one nanosecond after the rising edge. It changes the configuration only at points where the checker's own count of qualifying edges restarts in the same way the design's count does.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic follow; // filter off: stored level tracks the raw pin
    logic commit; // window finished: stored level takes the raw pin
  } dbnc_strobe_t;
endpackage

// File: rtl/dbnc_ctrl.sv
module dbnc_ctrl
  import dbnc_pkg::*;
#(
  parameter int CYCLES_PER_MS = 1000,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              mismatch,
  input  logic              cfgChg,
  output dbnc_strobe_t      strobe
);
  localparam int MAX_EXP = (1 << CODE_W) - 1;
  localparam int MS_W    = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic            restart;
  logic            msTick;
  logic            lastMs;
  logic            windowDone;
  logic [MS_W-1:0] msQ;
  logic [MS_W-1:0] msLimit;

  assign restart    = !enIn || !mismatch || cfgChg;
  assign msLimit    = MS_W'((32'd1 << codeIn) - 32'd1);
  assign lastMs     = (msQ == msLimit);
  assign windowDone = !restart && msTick && lastMs;

  generate
    if (CYCLES_PER_MS > 1) begin : g_pre
      localparam int PRE_W = $clog2(CYCLES_PER_MS);
      logic [PRE_W-1:0] preQ;
      assign msTick = (preQ == PRE_W'(CYCLES_PER_MS - 1));
      always_ff @(posedge clk) begin
        if (!rstN || restart || msTick) preQ <= '0;
        else                            preQ <= preQ + 1'b1;
      end
    end else begin : g_nopre
      assign msTick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || restart || windowDone) msQ <= '0;
    else if (msTick)                    msQ <= msQ + 1'b1;
  end

  always_comb begin
    strobe.follow = !enIn;
    strobe.commit = windowDone;
  end
endmodule

// File: rtl/dbnc_path.sv
module dbnc_path
  import dbnc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic              enIn,
  input  logic [CODE_W-1:0] codeIn,
  input  dbnc_strobe_t      strobe,
  output logic              mismatch,
  output logic              cfgChg,
  output logic              filtOut
);
  logic              filtQ;
  logic [CODE_W:0]   cfgQ;

  always_ff @(posedge clk) begin
    cfgQ <= {enIn, codeIn};
    if (!rstN || strobe.follow || strobe.commit) filtQ <= rawIn;
  end

  assign mismatch = (rawIn != filtQ);
  assign cfgChg   = ({enIn, codeIn} != cfgQ);
  assign filtOut  = enIn ? filtQ : rawIn;
endmodule

// File: rtl/ms_debounce_filter.sv
module ms_debounce_filter
  import dbnc_pkg::*;
#(
  parameter int CYCLES_PER_MS = 1000,
  parameter int CODE_W        = 3,
  parameter int CTRL_W        = 9,
  parameter int EN_POS        = 8,
  parameter int CODE_POS      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic              filtOut
);
  logic              enIn;
  logic [CODE_W-1:0] codeIn;
  logic              mismatch;
  logic              cfgChg;
  logic              unusedCtrl;
  dbnc_strobe_t      strobe;

  assign enIn       = ctrlWord[EN_POS];
  assign codeIn     = ctrlWord[CODE_POS +: CODE_W];
  assign unusedCtrl = ^ctrlWord;

  dbnc_ctrl #(.CYCLES_PER_MS(CYCLES_PER_MS), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .codeIn(codeIn),
    .mismatch(mismatch), .cfgChg(cfgChg), .strobe(strobe)
  );

  dbnc_path #(.CODE_W(CODE_W)) u_path (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .enIn(enIn), .codeIn(codeIn),
    .strobe(strobe), .mismatch(mismatch), .cfgChg(cfgChg), .filtOut(filtOut)
  );
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker #(
  parameter int CPM      = 1000,
  parameter int CODE_W   = 3,
  parameter int CTRL_W   = 9,
  parameter int EN_POS   = 8,
  parameter int CODE_POS = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              rawIn,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              filtOut
);
  logic              en;
  logic [CODE_W-1:0] code;
  logic [CODE_W:0]   cfg;
  logic [CODE_W:0]   cfgQ;
  int                runLen;
  int                winCycles;

  assign en        = ctrlWord[EN_POS];
  assign code      = ctrlWord[CODE_POS +: CODE_W];
  assign cfg       = {en, code};
  assign winCycles = CPM << code;

  // Count of consecutive qualifying edges with the raw pin away from the output
  always_ff @(posedge clk) begin
    cfgQ <= cfg;
    if (!rstN) runLen <= 0;
    else if (en && cfg == cfgQ && rawIn != filtOut) runLen <= runLen + 1;
    else runLen <= 0;
  end

  p_no_early_r1: assert property (@(posedge clk) disable iff (!rstN)
    (en && rawIn != filtOut && runLen < winCycles - 1)
      |=> (cfg != $past(cfg) || $stable(filtOut)));

  p_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (en && cfg == cfgQ && rawIn != filtOut && runLen == winCycles - 1)
      |=> (cfg != $past(cfg) || filtOut == $past(rawIn)));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> (filtOut == rawIn));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && cfg == cfgQ && rawIn == filtOut)
      |=> (cfg != $past(cfg) || $stable(filtOut)));
endmodule

bind ms_debounce_filter dbnc_checker #(
  .CPM(CYCLES_PER_MS), .CODE_W(CODE_W), .CTRL_W(CTRL_W),
  .EN_POS(EN_POS), .CODE_POS(CODE_POS)
) u_chk (
  .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctrlWord(ctrlWord), .filtOut(filtOut)
);

// File: tb/sim_ms_debounce_filter.sv
`timescale 1ns/1ps
module sim_ms_debounce_filter;
  localparam int CPM = 4;

  typedef struct packed {
    logic [2:0]  code;
    logic [11:0] hold;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 12'd3},   '{3'd0, 12'd4},   '{3'd1, 12'd7},  '{3'd1, 12'd8},
    '{3'd2, 12'd16},  '{3'd3, 12'd31},  '{3'd3, 12'd32}, '{3'd5, 12'd200},
    '{3'd7, 12'd511}, '{3'd7, 12'd512}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b1;
  logic [8:0] ctrlWord = 9'h100;
  logic       filtOut;
  logic       lvl;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  ms_debounce_filter #(.CYCLES_PER_MS(CPM)) u0 (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctrlWord(ctrlWord), .filtOut(filtOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [8:0] cw(input logic en, input logic [2:0] code, input logic [4:0] junk);
    return {en, code, junk};
  endfunction

  initial begin
    // R7: reset loads raw level at every edge, no filtering
    edges(3);
    check("R7 reset load 1", filtOut, 1'b1);
    @(negedge clk) rawIn = 1'b0;
    edges(1);
    check("R7 reset follows raw", filtOut, 1'b0);
    @(negedge clk) rstN = 1'b1;
    edges(1);
    check("R7 level kept after release", filtOut, 1'b0);
    lvl = 1'b0;

    // R1 R2 R4 R9: table of window lengths
    foreach (VEC[i]) begin
      logic exp;
      int   win;
      win = CPM << VEC[i].code;
      @(negedge clk) ctrlWord = cw(1'b1, VEC[i].code, 5'd0);
      edges(2);
      @(negedge clk) rawIn = ~lvl;
      edges(int'(VEC[i].hold));
      exp = (int'(VEC[i].hold) >= win) ? ~lvl : lvl;
      check(exp == lvl ? "R1 held before window" : "R2 R4 R9 change at window", filtOut, exp);
      if (exp != lvl) lvl = exp;
      else begin
        @(negedge clk) rawIn = lvl;
        edges(2);
      end
    end

    // R5: glitch back to the filtered level restarts the count (window 8)
    @(negedge clk) ctrlWord = cw(1'b1, 3'd1, 5'd0);
    edges(2);
    @(negedge clk) rawIn = ~lvl;
    edges(5);
    @(negedge clk) rawIn = lvl;
    edges(1);
    check("R5 glitch ignored", filtOut, lvl);
    @(negedge clk) rawIn = ~lvl;
    edges(7);
    check("R5 count restarted", filtOut, lvl);
    edges(1);
    check("R5 full window after restart", filtOut, ~lvl);
    lvl = ~lvl;

    // R6: code change mid-window restarts, output held
    @(negedge clk) rawIn = ~lvl;
    edges(5);
    @(negedge clk) ctrlWord = cw(1'b1, 3'd2, 5'd0);
    edges(16);
    check("R6 output held after code change", filtOut, lvl);
    edges(1);
    check("R6 new window completes", filtOut, ~lvl);
    lvl = ~lvl;

    // R6: enable toggle restarts (off one cycle with raw matching)
    @(negedge clk) rawIn = ~lvl;
    edges(10);
    @(negedge clk) begin ctrlWord = cw(1'b0, 3'd2, 5'd0); rawIn = lvl; end
    @(negedge clk) begin ctrlWord = cw(1'b1, 3'd2, 5'd0); rawIn = ~lvl; end
    #1;
    check("R6 enable toggle holds level", filtOut, lvl);
    edges(16);
    check("R6 restarted after enable", filtOut, lvl);
    edges(1);
    check("R6 window after enable", filtOut, ~lvl);
    lvl = ~lvl;

    // R3: filter off passes raw straight through
    @(negedge clk) ctrlWord = cw(1'b0, 3'd7, 5'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) rawIn = ~rawIn;
      #1;
      check("R3 bypass", filtOut, rawIn);
    end
    @(negedge clk) rawIn = 1'b1;
    edges(1);
    @(negedge clk) ctrlWord = cw(1'b1, 3'd0, 5'd0);
    #1;
    check("R3 re-enable starts from raw", filtOut, 1'b1);
    lvl = 1'b1;
    edges(2);

    // R8: low control bits changing every cycle do not restart
    @(negedge clk) rawIn = ~lvl;
    for (int k = 0; k < 3; k++) begin
      edges(1);
      check("R8 no early change", filtOut, lvl);
      @(negedge clk) ctrlWord = cw(1'b1, 3'd0, 5'(k * 7 + 3));
    end
    edges(1);
    check("R8 low bits ignored", filtOut, ~lvl);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule